// File: doc/BRIEF.md
# Interrupt Claim and Notify Engine

The engine tracks a pending bit and a claimed bit for each of a set of level-driven interrupt sources. It turns them into one notification line per target context. A source counts toward a context when four conditions hold: it is pending, it is not claimed, the context has it enabled, and its priority is strictly above the context's threshold. The threshold, the per-source priorities and the per-context enable masks arrive on plain input ports. No registers for these values live inside the block.

A handler takes work with a one-cycle claim strobe that names its context. In the same cycle the engine returns the lowest-numbered source that counts for that context. At the next clock edge that source moves from pending to claimed. A claimed source stays masked for every context until a one-cycle complete strobe names it. Source number 0 is reserved, so a returned ID of 0 always means that nothing was available. Both strobes are accepted in every cycle. There is no back-pressure, and the claim reply is combinational, so it needs no handshake.

Top module: `irq_notify_engine`

## Requirements
- R1: A synchronous reset clears every pending and claimed bit and the stored request levels. In the cycle after a reset edge, all notify lines are low and a claim returns 0.
- R2: The pending bit of a source follows changes of its request line. At a clock edge where the line differs from the previous cycle's value, pending takes the new value. A line held steady leaves pending unchanged, so a source that was claimed and then completed does not become pending again until its line drops and rises.
- R3: A source counts for context c only when it is pending, not claimed, enabled in bit c*NUM_SRC+s of ctx_enable, and its priority (src_prio bits s*PRIO_W upward) is strictly greater than the threshold of context c (ctx_thresh bits c*PRIO_W upward). A priority equal to the threshold does not count. Source 0 never counts.
- R4: notify[c] is high in exactly those cycles in which at least one source counts for context c. It follows changes of threshold and enable inputs in the same cycle.
- R5: While claim_req is high, claim_id in that same cycle gives the lowest-numbered source that counts for context claim_ctx, whatever the priorities of higher-numbered sources. While claim_req is low, claim_id is 0.
- R6: A claim that returns a nonzero ID clears that source's pending bit and sets its claimed bit at the next edge. From then on the source is masked for all contexts.
- R7: A claim that finds no qualifying source returns 0 and changes no state.
- R8: A complete strobe clears the claimed bit of source complete_id if complete_id < NUM_SRC. complete_id is ID_W+1 bits wide. Values of NUM_SRC and above have no effect.
- R9: When a claim and a complete name the same source in one cycle, the claim takes effect and the source ends up claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_level | input | NUM_SRC | Request line of each source |
| src_prio | input | NUM_SRC*PRIO_W | Priority of each source, source s at bits s*PRIO_W upward |
| ctx_enable | input | NUM_CTX*NUM_SRC | Enable mask of each context, context c at bits c*NUM_SRC upward |
| ctx_thresh | input | NUM_CTX*PRIO_W | Threshold of each context, context c at bits c*PRIO_W upward |
| claim_req | input | 1 | One-cycle claim strobe |
| claim_ctx | input | CTX_W | Context that issues the claim |
| claim_id | output | ID_W | Claimed source ID, valid in the cycle of claim_req, 0 if none |
| complete_req | input | 1 | One-cycle completion strobe |
| complete_id | input | ID_W+1 | Source to release |
| notify | output | NUM_CTX | Interrupt notification, one line per context |

## Verification
The properties assume that claim_ctx always names an existing context. They also assume that priorities, enables and thresholds are settled before the clock edge at which a claim or complete is sampled. The bench changes every input only at the falling clock edge. It draws context numbers modulo NUM_CTX, so the first assumption holds. It draws completion IDs over the full ID_W+1 bit range, so many of them land out of range. Other completion IDs are steered toward sources that are currently claimed, so releases happen often.

// File: rtl/irqn_pkg.sv
`timescale 1ns/1ps
package irqn_pkg;
  localparam int DEF_NUM_SRC = 32;
  localparam int DEF_NUM_CTX = 2;
  localparam int DEF_PRIO_W  = 3;

  // index width that stays at least one bit for a single context
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irqn_state.sv
`timescale 1ns/1ps
module irqn_state #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] level,
  input  logic [NUM_SRC-1:0] clr_pend,
  input  logic [NUM_SRC-1:0] set_clm,
  input  logic [NUM_SRC-1:0] clr_clm,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_SRC-1:0] claimed
);
  logic [NUM_SRC-1:0] level_q;
  logic [NUM_SRC-1:0] changed;

  assign changed = level ^ level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      pending <= '0;
      claimed <= '0;
    end else begin
      level_q <= level;
      // a fresh level change overrides the clear from a claim
      pending <= ((pending & ~clr_pend) & ~changed) | (level & changed);
      // a claim's set overrides a completion's clear (R9)
      claimed <= (claimed & ~clr_clm) | set_clm;
    end
  end
endmodule

// File: rtl/irqn_qualify.sv
`timescale 1ns/1ps
module irqn_qualify #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_SRC-1:0]        pending,
  input  logic [NUM_SRC-1:0]        claimed,
  input  logic [NUM_SRC-1:0]        enable,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thresh,
  output logic [NUM_SRC-1:0]        qual
);
  logic [NUM_SRC-1:0] raw;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign raw[s] = pending[s] & ~claimed[s] & enable[s]
                  & (prio[s*PRIO_W +: PRIO_W] > thresh);
  end

  // source 0 is reserved and never counts (R3)
  assign qual = raw & ~NUM_SRC'(1);
endmodule

// File: rtl/irqn_pick.sv
`timescale 1ns/1ps
module irqn_pick #(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC-1:0] vec,
  output logic [ID_W-1:0]    id
);
  always_comb begin
    id = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (vec[s]) id = ID_W'(s);
    end
  end
endmodule

// File: rtl/irq_notify_engine.sv
`timescale 1ns/1ps
module irq_notify_engine
  import irqn_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int NUM_CTX = DEF_NUM_CTX,
  parameter int PRIO_W  = DEF_PRIO_W,
  localparam int ID_W   = $clog2(NUM_SRC),
  localparam int CTX_W  = idx_bits(NUM_CTX)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          src_level,
  input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
  input  logic [NUM_CTX*NUM_SRC-1:0]  ctx_enable,
  input  logic [NUM_CTX*PRIO_W-1:0]   ctx_thresh,
  input  logic                        claim_req,
  input  logic [CTX_W-1:0]            claim_ctx,
  output logic [ID_W-1:0]             claim_id,
  input  logic                        complete_req,
  input  logic [ID_W:0]               complete_id,
  output logic [NUM_CTX-1:0]          notify
);
  localparam logic [ID_W:0] CID_LIMIT = (ID_W + 1)'(NUM_SRC);

  logic [NUM_SRC-1:0] pending, claimed;
  logic [NUM_SRC-1:0] clr_pend, set_clm, clr_clm;
  logic [NUM_SRC-1:0] qual [NUM_CTX];
  logic [NUM_SRC-1:0] sel;
  logic [ID_W-1:0]    pick_id;
  logic               take, release_ok;

  irqn_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk(clk), .rst(rst), .level(src_level),
    .clr_pend(clr_pend), .set_clm(set_clm), .clr_clm(clr_clm),
    .pending(pending), .claimed(claimed)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irqn_qualify #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_qual (
      .pending(pending), .claimed(claimed),
      .enable(ctx_enable[c*NUM_SRC +: NUM_SRC]),
      .prio(src_prio),
      .thresh(ctx_thresh[c*PRIO_W +: PRIO_W]),
      .qual(qual[c])
    );
    assign notify[c] = |qual[c];
  end

  always_comb begin
    sel = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (CTX_W'(c) == claim_ctx) sel = qual[c];
    end
  end

  irqn_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
    .vec(sel), .id(pick_id)
  );

  assign claim_id   = claim_req ? pick_id : '0;
  assign take       = claim_req && (pick_id != '0);
  assign clr_pend   = take ? (NUM_SRC'(1) << pick_id) : '0;
  assign set_clm    = clr_pend;
  assign release_ok = complete_req && (complete_id < CID_LIMIT);
  assign clr_clm    = release_ok ? (NUM_SRC'(1) << complete_id[ID_W-1:0]) : '0;
endmodule

// File: rtl/irqn_checker.sv
`timescale 1ns/1ps
module irqn_checker #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int ID_W    = 5,
  parameter int CTX_W   = 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_CTX*NUM_SRC-1:0] ctx_enable,
  input logic                       claim_req,
  input logic [CTX_W-1:0]           claim_ctx,
  input logic [ID_W-1:0]            claim_id,
  input logic [NUM_CTX-1:0]         notify
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  a_r1_reset_quiet: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (notify == '0));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !claim_req |-> (claim_id == '0));

  a_r5_hit_nonzero: assert property (@(posedge clk) disable iff (rst)
    (claim_req && notify[claim_ctx]) |-> (claim_id != '0));

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (claim_req && !notify[claim_ctx]) |-> (claim_id == '0));

  a_r6_no_reclaim: assert property (@(posedge clk) disable iff (rst)
    (claim_req && claim_id != '0) |=> !(claim_req && claim_id == $past(claim_id)));

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_en
    a_r3_disabled_silent: assert property (@(posedge clk) disable iff (rst)
      (ctx_enable[c*NUM_SRC +: NUM_SRC] == '0) |-> !notify[c]);
  end
endmodule

bind irq_notify_engine irqn_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ID_W(ID_W), .CTX_W(CTX_W)
) u_chk (
  .clk(clk), .rst(rst), .ctx_enable(ctx_enable), .claim_req(claim_req),
  .claim_ctx(claim_ctx), .claim_id(claim_id), .notify(notify)
);

// File: tb/sim_irq_notify_engine.sv
`timescale 1ns/1ps
module sim_irq_notify_engine;
  localparam int N  = 32;
  localparam int C  = 2;
  localparam int P  = 3;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]   lvl = '0;
  logic [N*P-1:0] prio = '0;
  logic [C*N-1:0] en = '0;
  logic [C*P-1:0] thr = '0;
  logic           claim_req = 1'b0;
  logic [0:0]     claim_ctx = '0;
  logic [IW-1:0]  claim_id;
  logic           complete_req = 1'b0;
  logic [IW:0]    complete_id = '0;
  logic [C-1:0]   notify;

  irq_notify_engine u0 (
    .clk(clk), .rst(rst), .src_level(lvl), .src_prio(prio),
    .ctx_enable(en), .ctx_thresh(thr), .claim_req(claim_req),
    .claim_ctx(claim_ctx), .claim_id(claim_id), .complete_req(complete_req),
    .complete_id(complete_id), .notify(notify)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [N-1:0] m_pend = '0, m_clm = '0, m_lvlq = '0;

  function automatic logic [N-1:0] m_qual(input int c);
    logic [N-1:0] q = '0;
    for (int s = 1; s < N; s++)
      q[s] = m_pend[s] & ~m_clm[s] & en[c*N+s] & (prio[s*P +: P] > thr[c*P +: P]);
    return q;
  endfunction

  function automatic int m_pick(input int c);
    logic [N-1:0] q = m_qual(c);
    for (int s = 1; s < N; s++) if (q[s]) return s;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // called just after a falling edge with inputs set; returns at the next falling edge
  task automatic step(input string tag);
    int e_id;
    logic [C-1:0] e_n;
    logic [N-1:0] np, nc;
    #2;
    for (int c = 0; c < C; c++) e_n[c] = |m_qual(c);
    e_id = claim_req ? m_pick(int'(claim_ctx)) : 0;
    chk(notify == e_n, {tag, " notify"}, int'(notify), int'(e_n));
    chk(claim_id == IW'(e_id), {tag, " claim id"}, int'(claim_id), e_id);
    @(posedge clk);
    np = m_pend; nc = m_clm;
    if (complete_req && complete_id < N) nc[complete_id[IW-1:0]] = 1'b0;
    if (e_id != 0) begin np[e_id] = 1'b0; nc[e_id] = 1'b1; end
    for (int s = 0; s < N; s++) if (lvl[s] != m_lvlq[s]) np[s] = lvl[s];
    m_pend = np; m_clm = nc; m_lvlq = lvl;
    @(negedge clk);
    claim_req = 1'b0;
    complete_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    #2;
    chk(notify == '0, "R1 notify in reset", int'(notify), 0);
    claim_req = 1'b1;
    #1;
    chk(claim_id == '0, "R1 claim in reset", int'(claim_id), 0);
    rst = 1'b0;
    @(negedge clk);
    claim_req = 1'b1;
    step("R7 empty claim");

    // strict threshold compare
    en = '1;
    prio[5*P +: P] = 3'd3;
    thr = {3'd2, 3'd3};
    lvl[5] = 1'b1;
    step("R2 rise");
    #2 chk(notify == 2'b10, "R3 strict threshold", int'(notify), 2);

    // reserved source 0
    lvl[0] = 1'b1;
    prio[0 +: P] = 3'd7;
    step("R3 src0");
    #2 chk(notify[0] == 1'b0, "R3 source zero", int'(notify[0]), 0);

    // lowest index wins over higher priority
    prio[9*P +: P] = 3'd7;
    lvl[9] = 1'b1;
    step("R2 rise");
    thr[0 +: P] = 3'd0;
    claim_req = 1'b1; claim_ctx = 1'b0;
    #2 chk(claim_id == 5, "R5 lowest index", int'(claim_id), 5);
    step("R5");
    claim_req = 1'b1; claim_ctx = 1'b0;
    #2 chk(claim_id == 9, "R6 next after claim", int'(claim_id), 9);
    step("R6");
    claim_req = 1'b1; claim_ctx = 1'b1;
    #2 chk(claim_id == 0, "R6 masked for other context", int'(claim_id), 0);
    step("R6");

    // out-of-range completion (37 aliases 5 if truncated)
    complete_req = 1'b1; complete_id = 6'd37;
    step("R8");
    lvl[5] = 1'b0; step("R2");
    lvl[5] = 1'b1; step("R2");
    #2 chk(notify == '0, "R8 out-of-range ignored", int'(notify), 0);
    complete_req = 1'b1; complete_id = 6'd5;
    step("R8");
    #2 chk(notify == 2'b11, "R8 complete releases", int'(notify), 3);

    // steady level does not re-pend
    claim_req = 1'b1; claim_ctx = 1'b1;
    step("R5");
    complete_req = 1'b1; complete_id = 6'd5;
    step("R8");
    #2 chk(notify == '0, "R2 steady level", int'(notify), 0);

    // claim and complete of the same source in one cycle
    lvl[5] = 1'b0; step("R2");
    lvl[5] = 1'b1; step("R2");
    claim_req = 1'b1; claim_ctx = 1'b0;
    complete_req = 1'b1; complete_id = 6'd5;
    step("R9");
    lvl[5] = 1'b0; step("R9");
    lvl[5] = 1'b1; step("R9");
    #2 chk(notify == '0, "R9 claim beats complete", int'(notify), 0);

    // reset in mid-run
    rst = 1'b1;
    @(posedge clk);
    m_pend = '0; m_clm = '0; m_lvlq = '0;
    @(negedge clk);
    #2 chk(notify == '0, "R1 reset clears", int'(notify), 0);
    rst = 1'b0;
    step("R1 release");

    // constrained random phase
    en = {$urandom, $urandom};
    for (int s = 0; s < N; s++) prio[s*P +: P] = P'($urandom);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) lvl[$urandom % N] ^= 1'b1;
      if ($urandom % 16 == 0) prio[($urandom % N)*P +: P] = P'($urandom);
      if ($urandom % 32 == 0) en[$urandom % (C*N)] ^= 1'b1;
      if ($urandom % 32 == 0) thr[($urandom % C)*P +: P] = P'($urandom);
      claim_req = ($urandom % 3 == 0);
      claim_ctx = 1'($urandom % C);
      complete_req = ($urandom % 4 == 0);
      if ($urandom % 3 == 0) complete_id = 6'($urandom % 64);
      else begin
        int r = $urandom % N;
        complete_id = 6'(r);
        for (int k = 0; k < N; k++)
          if (m_clm[(r+k)%N]) begin complete_id = 6'((r+k)%N); break; end
      end
      step("R4/R5 random");
    end

    done = 1'b1;
    finish_run();
  end
endmodule